// File: doc/BRIEF.md
# Decimal Shift-and-Round Unit

This unit moves a signed packed-decimal value left or right by a whole number of decimal digits. It rounds right shifts half-up. It writes a canonical sign code back into the result and produces a 4-bit condition code that compares the result against zero. The data operand is 128 bits wide: 31 BCD digits, with the sign code in the least significant nibble. A separate 128-bit shift source supplies a signed digit count in its low byte.

The unit works in one registered cycle. When `in_valid` is high on a rising clock edge, the unit computes the operation from that cycle's inputs and loads the result and condition code into the output registers. `out_valid` marks the cycle that follows. While `in_valid` is low, the outputs keep their last value.

Top module: `dsr_unit`

## Requirements
- R1: An asynchronous active-low reset clears `out_valid`, `result` and `cc` to zero. An operation accepted on a clock edge with `in_valid` high appears on `result` and `cc` after that edge, and `out_valid` is high for exactly that one cycle. With `in_valid` low, `result` and `cc` hold their values.
- R2: The shift count is bits [7:0] of `op_cnt`, read as a two's-complement byte. All higher bits are ignored. A count above zero shifts toward the most significant digit. A count of zero or below shifts toward the least significant digit by its magnitude.
- R3: The shift distance saturates at 31 digits. A count above 31 acts as a left shift by 31, and a count below -31 acts as a right shift by 31.
- R4: The sign nibble is replaced by zero before the shift, and each digit moves the value by four bit positions. The old sign code therefore never appears among the result digits.
- R5: On a left shift, condition-code bit 0 (SO) is set when any nonzero digit leaves the top of the 128-bit value. A right shift never sets it.
- R6: On a right shift, if the digit that lands in nibble 0 is 5 or greater, decimal one is added at digit position 1 (bits [7:4]), with carries passed upward digit by digit (9 becomes 0 plus a carry).
- R7: The sign nibble of the result is 0xD when the operand's sign code is 0xB or 0xD. For the positive codes 0xA, 0xC, 0xE and 0xF, it is 0xC when `pref_sel` is 0 and 0xF when `pref_sel` is 1.
- R8: If any digit nibble (bits [127:4]) exceeds 9, or the sign nibble is below 0xA, the operand is invalid and `cc` is exactly 4'b0001.
- R9: For a valid operand, `cc` is {LT, GT, EQ, SO} from bit 3 down to bit 0. EQ is set when all result digits are zero, whatever the sign. Otherwise LT is set for a negative sign and GT for a positive one. At most one of LT, GT and EQ is set.
- R10: The comparison uses the rounded result, so a right shift that would leave zero but rounds up reports LT or GT rather than EQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the operands on this edge |
| op_a | input | 128 | Packed-decimal operand, sign code in bits [3:0] |
| op_cnt | input | 128 | Shift source; signed digit count in bits [7:0] |
| pref_sel | input | 1 | Selects 0xF instead of 0xC as the positive sign code |
| out_valid | output | 1 | Result and condition code were updated on the last edge |
| result | output | 128 | Shifted, rounded packed-decimal result |
| cc | output | 4 | Condition code {LT, GT, EQ, SO} |

## Verification
Two pairs of functions can act in the same cycle, and the vectors provoke both:

- **Saturation and rounding.** A count of -128 saturates to 31 digits and moves the top digit, a 5, into the rounding position. The increment then turns an all-zero magnitude into 1, so the bench expects 0x1C and GT rather than EQ.
- **Overflow and a nonzero result.** A left shift by one drops a nonzero top digit while a lower digit survives. With a negative operand, the bench expects LT and SO together.

Each result is judged against a hand-worked value and condition code.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam int NIB = 4;

  // canonical sign codes written into the result
  typedef enum logic [NIB-1:0] {
    SGN_POS_STD = 4'hC,
    SGN_NEG     = 4'hD,
    SGN_POS_ALT = 4'hF
  } sign_code_e;

  // condition-code bit positions
  localparam int CC_LT = 3;
  localparam int CC_GT = 2;
  localparam int CC_EQ = 1;
  localparam int CC_SO = 0;

  function automatic logic code_is_neg(input logic [NIB-1:0] code);
    return (code == 4'hB) || (code == 4'hD);
  endfunction

  function automatic sign_code_e pick_sign(input logic neg, input logic alt);
    if (neg)      return SGN_NEG;
    else if (alt) return SGN_POS_ALT;
    else          return SGN_POS_STD;
  endfunction

endpackage

// File: rtl/dsr_validate.sv
module dsr_validate
  import dsr_pkg::*;
#(
  parameter int DIGITS = 31,
  localparam int W = NIB * (DIGITS + 1)
) (
  input  logic [W-1:0] op,
  output logic         ok,
  output logic         neg
);

  logic [DIGITS:1] dig_ok;
  logic            sign_ok;

  for (genvar k = 1; k <= DIGITS; k++) begin : g_dig
    assign dig_ok[k] = (op[NIB*k +: NIB] <= 4'd9);
  end

  assign sign_ok = (op[NIB-1:0] >= 4'hA);
  assign ok      = sign_ok && (&dig_ok);
  assign neg     = code_is_neg(op[NIB-1:0]);

endmodule

// File: rtl/dsr_shift.sv
module dsr_shift
  import dsr_pkg::*;
#(
  parameter int DIGITS = 31,
  parameter int CNT_W  = 8,
  localparam int W     = NIB * (DIGITS + 1),
  localparam int AMT_W = $clog2(DIGITS + 1)
) (
  input  logic [W-1:0]     mag,
  input  logic [CNT_W-1:0] cnt,
  output logic             go_left,
  output logic [W-1:0]     shifted,
  output logic             ovf
);

  localparam logic [CNT_W:0] SAT = (CNT_W + 1)'(DIGITS);

  logic [CNT_W:0] cnt_mag;
  logic [AMT_W-1:0] amt;
  logic [W-1:0] lstg [AMT_W+1];
  logic [W-1:0] rstg [AMT_W+1];
  logic [AMT_W-1:0] lost;

  // count decode: sign picks direction, magnitude saturates
  always_comb begin
    go_left = !cnt[CNT_W-1] && (|cnt);
    if (go_left) cnt_mag = {1'b0, cnt};
    else         cnt_mag = (CNT_W + 1)'(0) - {cnt[CNT_W-1], cnt};
    if (cnt_mag > SAT) amt = AMT_W'(DIGITS);
    else               amt = cnt_mag[AMT_W-1:0];
  end

  assign lstg[0] = mag;
  assign rstg[0] = mag;

  // log-depth digit shifter, one stage per amount bit
  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SB = NIB * (1 << s);
    assign lstg[s+1] = amt[s] ? {lstg[s][W-1-SB:0], {SB{1'b0}}} : lstg[s];
    assign rstg[s+1] = amt[s] ? {{SB{1'b0}}, rstg[s][W-1:SB]} : rstg[s];
    assign lost[s]   = amt[s] && (|lstg[s][W-1 -: SB]);
  end

  assign shifted = go_left ? lstg[AMT_W] : rstg[AMT_W];
  assign ovf     = go_left && (|lost);

endmodule

// File: rtl/dsr_round.sv
module dsr_round
  import dsr_pkg::*;
#(
  parameter int DIGITS = 31,
  localparam int W = NIB * (DIGITS + 1)
) (
  input  logic [W-1:0] din,
  input  logic         inc,
  output logic [W-1:0] dout
);

  logic [DIGITS:1] carry;

  assign carry[1]       = inc;
  assign dout[NIB-1:0]  = din[NIB-1:0];

  // BCD increment at digit 1, ripple through runs of nines
  for (genvar k = 1; k <= DIGITS; k++) begin : g_dig
    logic [NIB-1:0] d;
    logic           nine;
    assign d    = din[NIB*k +: NIB];
    assign nine = (d == 4'd9);
    assign dout[NIB*k +: NIB] = (carry[k] && nine) ? 4'd0 : d + {3'b000, carry[k]};
    if (k < DIGITS) begin : g_c
      assign carry[k+1] = carry[k] && nine;
    end
  end

endmodule

// File: rtl/dsr_unit.sv
module dsr_unit
  import dsr_pkg::*;
#(
  parameter int DIGITS  = 31,
  parameter int CNT_W   = 8,
  parameter int CNT_LSB = 0,
  localparam int W = NIB * (DIGITS + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_cnt,
  input  logic         pref_sel,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic [3:0]   cc
);

  logic             op_ok, op_neg;
  logic [W-1:0]     mag, shifted, rounded, final_val;
  logic             go_left, ovf, rnd_inc, is_zero;
  logic [CNT_W-1:0] cnt;
  logic             unused_src;
  sign_code_e       out_sign;

  logic [W-1:0] result_d;
  logic [3:0]   cc_d;

  assign mag        = {op_a[W-1:NIB], {NIB{1'b0}}};
  assign cnt        = op_cnt[CNT_LSB +: CNT_W];
  assign unused_src = ^op_cnt;

  dsr_validate #(.DIGITS(DIGITS)) u_val (
    .op (op_a),
    .ok (op_ok),
    .neg(op_neg)
  );

  dsr_shift #(.DIGITS(DIGITS), .CNT_W(CNT_W)) u_shf (
    .mag    (mag),
    .cnt    (cnt),
    .go_left(go_left),
    .shifted(shifted),
    .ovf    (ovf)
  );

  assign rnd_inc = !go_left && (shifted[NIB-1:0] >= 4'd5);

  dsr_round #(.DIGITS(DIGITS)) u_rnd (
    .din (shifted),
    .inc (rnd_inc),
    .dout(rounded)
  );

  assign out_sign  = pick_sign(op_neg, pref_sel);
  assign final_val = {rounded[W-1:NIB], out_sign};
  assign is_zero   = ~|final_val[W-1:NIB];

  // next-state: load on in_valid, hold otherwise
  always_comb begin
    result_d = result;
    cc_d     = cc;
    if (in_valid) begin
      result_d = final_val;
      if (!op_ok) begin
        cc_d = 4'b0001;
      end else begin
        cc_d[CC_LT] = !is_zero && op_neg;
        cc_d[CC_GT] = !is_zero && !op_neg;
        cc_d[CC_EQ] = is_zero;
        cc_d[CC_SO] = ovf;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cc        <= '0;
    end else begin
      out_valid <= in_valid;
      result    <= result_d;
      cc        <= cc_d;
    end
  end

  // R8
  invalid_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op_ok |=> cc == 4'b0001);

  // R9
  zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cc[CC_EQ] |-> result[W-1:NIB] == '0);

  // R9
  cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(cc[3:1]));

  // R7
  neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cc[CC_LT] |-> result[NIB-1:0] == 4'hD);

  // R5
  right_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_ok && !go_left |=> !cc[CC_SO]);

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(cc));

endmodule

// File: tb/dsr_unit_test.sv
`timescale 1ns/1ps
module dsr_unit_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] op_a;
  logic [127:0] op_cnt;
  logic         pref_sel;
  logic         out_valid;
  logic [127:0] result;
  logic [3:0]   cc;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  dsr_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
    .op_cnt(op_cnt), .pref_sel(pref_sel), .out_valid(out_valid),
    .result(result), .cc(cc)
  );

  typedef struct packed {
    logic [127:0] op;
    logic [7:0]   cnt;
    logic         sel;
    logic         chk;
    logic [127:0] res;
    logic [3:0]   ccx;
    logic [7:0]   req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{128'h123C, 8'h01, 1'b0, 1'b1, 128'h1230C, 4'b0100, 8'd2},   // R2 left 1
    '{128'h123C, 8'hFF, 1'b0, 1'b1, 128'h12C, 4'b0100, 8'd2},     // R2 right 1, no round
    '{128'h125D, 8'hFF, 1'b0, 1'b1, 128'h13D, 4'b1000, 8'd6},     // R6 round up
    '{128'h9996C, 8'hFF, 1'b0, 1'b1, 128'h1000C, 4'b0100, 8'd6},  // R6 carry chain
    '{128'h123A, 8'h00, 1'b1, 1'b1, 128'h123F, 4'b0100, 8'd7},    // R7 alt positive
    '{128'h45B, 8'h00, 1'b1, 1'b1, 128'h45D, 4'b1000, 8'd7},      // R7 negative B
    '{128'h0D, 8'h00, 1'b0, 1'b1, 128'h0D, 4'b0010, 8'd9},        // R9 negative zero
    '{{4'h1, 120'h0, 4'hC}, 8'h01, 1'b0, 1'b1, 128'hC, 4'b0011, 8'd5},                   // R5 lost digit
    '{{4'h0, 4'h9, 116'h0, 4'hC}, 8'h01, 1'b0, 1'b1, {4'h9, 120'h0, 4'hC}, 4'b0100, 8'd5}, // R5 top digit kept
    '{128'h7C, 8'h64, 1'b0, 1'b1, 128'hC, 4'b0011, 8'd3},         // R3 left saturation
    '{{4'h5, 120'h0, 4'hC}, 8'h80, 1'b0, 1'b1, 128'h1C, 4'b0100, 8'd3},  // R3 right sat + round
    '{{4'h4, 120'h0, 4'hD}, 8'hD8, 1'b0, 1'b1, 128'hD, 4'b0010, 8'd3},   // R3 right sat, no round
    '{128'h1A3C, 8'h01, 1'b0, 1'b0, 128'h0, 4'b0001, 8'd8},       // R8 bad digit
    '{128'h1239, 8'hFF, 1'b0, 1'b0, 128'h0, 4'b0001, 8'd8},       // R8 bad sign
    '{128'h12E, 8'h03, 1'b0, 1'b1, 128'h12000C, 4'b0100, 8'd2},   // R2 left 3
    '{128'h9F, 8'h01, 1'b1, 1'b1, 128'h90F, 4'b0100, 8'd4},       // R4 sign cleared
    '{128'h12349C, 8'hFE, 1'b0, 1'b1, 128'h123C, 4'b0100, 8'd6},  // R6 only top dropped digit
    '{128'h5D, 8'hFF, 1'b0, 1'b1, 128'h1D, 4'b1000, 8'd10},       // R10 zero rounds to one
    '{{4'h3, 4'h2, 116'h0, 4'hB}, 8'h01, 1'b0, 1'b1, {4'h2, 120'h0, 4'hD}, 4'b1001, 8'd5} // R5 LT with SO
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] op, input logic [127:0] src, input logic sel);
    @(negedge clk);
    op_a = op; op_cnt = src; pref_sel = sel; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_cnt = '0; pref_sel = 1'b0;
    #1;
    // R1 reset state
    check("R1 reset out_valid", {127'h0, out_valid}, 128'h0);
    check("R1 reset result", result, 128'h0);
    check("R1 reset cc", {124'h0, cc}, 128'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      apply(VECS[i].op, {120'h0, VECS[i].cnt}, VECS[i].sel);
      check({tag, " out_valid R1"}, {127'h0, out_valid}, 128'h1);
      if (VECS[i].chk) check({tag, " result"}, result, VECS[i].res);
      check({tag, " cc"}, {124'h0, cc}, {124'h0, VECS[i].ccx});
    end

    // R2: upper bytes of the shift source are ignored
    apply(128'h123C, {120'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FF, 8'h01}, 1'b0);
    check("R2 upper src bytes result", result, 128'h1230C);
    check("R2 upper src bytes cc", {124'h0, cc}, 128'h4);

    // R1: outputs hold while in_valid is low
    @(negedge clk);
    op_a = 128'h999D; op_cnt = 128'hFF; pref_sel = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 hold out_valid", {127'h0, out_valid}, 128'h0);
    check("R1 hold result", result, 128'h1230C);
    check("R1 hold cc", {124'h0, cc}, 128'h4);

    // R1: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    check("R1 async reset result", result, 128'h0);
    check("R1 async reset cc", {124'h0, cc}, 128'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 + R7: carry through nines with alternate positive sign
    apply(128'h0999_9999_9AE0 + 128'h0, 8'hFF, 1'b1);
    check("R8 bad digit after reset cc", {124'h0, cc}, 128'h1);
    apply(128'h9999_9999_997E, 8'hFF, 1'b1);
    check("R6 long carry result", result, 128'h1000_0000_000F);
    check("R6 long carry cc", {124'h0, cc}, 128'h4);

    done = 1;
    finish_run();
  end

endmodule